// File: doc/BRIEF.md
# Half-Word to Word Register Access Bridge

This block sits between a master that may issue 8-, 16- or 32-bit accesses and a register file built only from 32-bit registers. Full-word accesses go straight through. Half-word accesses are combined so that each 32-bit register is always read or written as a whole. A half-word write to the lower half of a word is held in a staging register and does not reach the register file. The later write to the upper half sends one full-word write made of the new upper half and the staged lower half.

Reads work the other way round. Reading the lower half performs the real 32-bit read, returns the low 16 bits and keeps the high 16 bits in a latch. Reading the upper half then returns the latch and does not touch the register file. Any read side effect therefore happens once per word. Byte accesses and the reserved size code are refused with an error response.

The downstream side is a single-cycle request port. Its request signals are decoded from the upstream request in the same cycle. The register file answers with read data in that same cycle. The response to the master is registered and appears exactly one cycle after the request.

Top module: `half_word_bridge`

## Requirements
- R1: After reset the response outputs are low or zero, and both the staging register and the upper-half latch hold 0. An upper-half read issued first returns 0. An upper-half write issued first sends a lower half of 0.
- R2: A request with size code 2 (word) raises `dn_req` in the same cycle, with `dn_we`, `dn_addr` and `dn_wdata` equal to the upstream values. A word read returns the downstream read data one cycle later.
- R3: A half-word write (size code 1) with address bit 1 clear keeps `dn_req` low and stores `up_wdata[15:0]` in the staging register.
- R4: A half-word write with address bit 1 set issues exactly one downstream write. Its address is the request address with bits 1:0 cleared, and its data is `{up_wdata[15:0], staged lower half}`.
- R5: A half-word read with address bit 1 clear issues one downstream read at the address with bits 1:0 cleared. It returns the low 16 bits zero-extended one cycle later and latches the high 16 bits.
- R6: A half-word read with address bit 1 set keeps `dn_req` low and returns the latched upper half, zero-extended, one cycle later.
- R7: A request with size code 0 (byte) or 3 (reserved) keeps `dn_req` low. It raises `rsp_err` with zero read data for exactly the one response cycle, and it leaves the staging register and the latch unchanged.
- R8: Every request cycle is followed by exactly one `rsp_valid` cycle, and a cycle without a request by none. Write responses carry zero read data.
- R9: The staging register and the latch change only on the accesses named in R3 and R5. Word accesses and refused accesses in between do not disturb them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request present this cycle |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| up_addr | input | AW | Byte address |
| up_wdata | input | DW | Write data; half-word writes use bits 15:0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Access refused for bad width |
| rsp_rdata | output | DW | Read data, zero for writes and errors |
| dn_req | output | 1 | Downstream register access this cycle |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_rdata | input | DW | Downstream read data, valid in the request cycle |

## Verification
The assertions assume that the master holds reset for at least one edge before its first request. They also assume that `up_valid` is low during reset and that the downstream file answers reads in the same cycle as `dn_req`. The bench keeps to all three. It holds the request lines at zero through reset and drives `dn_rdata` combinationally from a bench memory. It issues requests only between edges. Addresses are confined to sixteen words so that staged writes and latched reads often meet word traffic to the same and to other registers.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WORD,
    OP_HW_STAGE,
    OP_HW_COMMIT,
    OP_HR_FETCH,
    OP_HR_UPPER,
    OP_BADW
  } bridge_op_e;
endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
  import hwb_pkg::*;
(
  input  logic       valid,
  input  logic       we,
  input  logic [1:0] size,
  input  logic       upper,
  output bridge_op_e op
);
  always_comb begin
    op = OP_IDLE;
    if (valid) begin
      unique case (size)
        SZ_WORD: op = OP_WORD;
        SZ_HALF: begin
          if (we) op = upper ? OP_HW_COMMIT : OP_HW_STAGE;
          else    op = upper ? OP_HR_UPPER  : OP_HR_FETCH;
        end
        default: op = OP_BADW;
      endcase
    end
  end
endmodule

// File: rtl/hwb_halfregs.sv
module hwb_halfregs #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stage_en,
  input  logic [HW-1:0] stage_d,
  input  logic          latch_en,
  input  logic [HW-1:0] latch_d,
  output logic [HW-1:0] stage_q,
  output logic [HW-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      latch_q <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (latch_en) latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/hwb_resp.sv
module hwb_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_d,
  input  logic          err_d,
  input  logic [DW-1:0] rdata_d,
  output logic          valid_q,
  output logic          err_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    err_q |-> valid_q); // R7
endmodule

// File: rtl/half_word_bridge.sv
module half_word_bridge
  import hwb_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  input  logic          up_we,
  input  logic [1:0]    up_size,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          dn_req,
  output logic          dn_we,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic [DW-1:0] dn_rdata
);
  localparam int HW = DW / 2;

  bridge_op_e    op;
  logic [HW-1:0] stage_q, latch_q;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] rd_next;
  logic          err_next;

  assign word_addr = {up_addr[AW-1:2], 2'b00};

  hwb_decode u_dec (
    .valid (up_valid),
    .we    (up_we),
    .size  (up_size),
    .upper (up_addr[1]),
    .op    (op)
  );

  hwb_halfregs #(.HW(HW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .stage_en (op == OP_HW_STAGE),
    .stage_d  (up_wdata[HW-1:0]),
    .latch_en (op == OP_HR_FETCH),
    .latch_d  (dn_rdata[DW-1:HW]),
    .stage_q  (stage_q),
    .latch_q  (latch_q)
  );

  always_comb begin
    dn_req   = 1'b0;
    dn_we    = 1'b0;
    dn_addr  = up_addr;
    dn_wdata = up_wdata;
    rd_next  = '0;
    err_next = 1'b0;
    unique case (op)
      OP_WORD: begin
        dn_req  = 1'b1;
        dn_we   = up_we;
        rd_next = up_we ? '0 : dn_rdata;
      end
      OP_HW_COMMIT: begin
        dn_req   = 1'b1;
        dn_we    = 1'b1;
        dn_addr  = word_addr;
        dn_wdata = {up_wdata[HW-1:0], stage_q};
      end
      OP_HR_FETCH: begin
        dn_req  = 1'b1;
        dn_addr = word_addr;
        rd_next = {{HW{1'b0}}, dn_rdata[HW-1:0]};
      end
      OP_HR_UPPER: rd_next = {{HW{1'b0}}, latch_q};
      OP_BADW:     err_next = 1'b1;
      default: ;
    endcase
  end

  hwb_resp #(.DW(DW)) u_resp (
    .clk     (clk),
    .rst     (rst),
    .valid_d (up_valid),
    .err_d   (err_next),
    .rdata_d (rd_next),
    .valid_q (rsp_valid),
    .err_q   (rsp_err),
    .rdata_q (rsp_rdata)
  );

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> !rsp_valid); // R8
  AST_WORD_PASSES: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_size == SZ_WORD) |-> (dn_req && dn_addr == up_addr && dn_we == up_we)); // R2
  AST_STAGE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_we && up_size == SZ_HALF && !up_addr[1]) |-> !dn_req); // R3
  AST_COMMIT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_we && up_size == SZ_HALF && up_addr[1]) |-> (dn_req && dn_we && dn_addr[1:0] == 2'b00)); // R4
  AST_UPPER_SILENT: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_we && up_size == SZ_HALF && up_addr[1]) |-> !dn_req); // R6
  AST_BADW_SILENT: assert property (@(posedge clk) disable iff (rst)
    (up_valid && (up_size == SZ_BYTE || up_size == SZ_RSVD)) |-> !dn_req); // R7
  AST_ERR_FROM_BADW: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(up_valid && (up_size == SZ_BYTE || up_size == SZ_RSVD))); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(up_valid && !up_we && up_size == SZ_HALF && !up_addr[1]) |=> $stable(latch_q)); // R9
  AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(up_valid && up_we && up_size == SZ_HALF && !up_addr[1]) |=> $stable(stage_q)); // R9
endmodule

// File: tb/half_word_bridge_bench.sv
module half_word_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          up_valid, up_we;
  logic [1:0]    up_size;
  logic [AW-1:0] up_addr;
  logic [DW-1:0] up_wdata;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          dn_req, dn_we;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata, dn_rdata;

  logic [DW-1:0] dev_mem [16];
  logic [DW-1:0] ref_mem [16];
  logic [15:0]   ref_stage, ref_latch;
  logic          exp_rv, exp_re;
  logic [DW-1:0] exp_rd;
  string         exp_tag;
  int            n_cmp = 0;
  int            n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  half_word_bridge #(.AW(AW), .DW(DW)) u_half_word_bridge (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_we(up_we), .up_size(up_size),
    .up_addr(up_addr), .up_wdata(up_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  assign dn_rdata = dev_mem[dn_addr[5:2]];

  always @(posedge clk) begin
    if (!rst && dn_req && dn_we) dev_mem[dn_addr[5:2]] <= dn_wdata;
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_rsp();
    chk(exp_tag, "rsp_valid", {63'd0, rsp_valid}, {63'd0, exp_rv});
    chk(exp_tag, "rsp_err", {63'd0, rsp_err}, {63'd0, exp_re});
    chk(exp_tag, "rsp_rdata", {32'd0, rsp_rdata}, {32'd0, exp_rd});
  endtask

  // one request cycle; called just after a falling edge
  task automatic step(input logic v, input logic we, input logic [1:0] sz,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
    logic          e_req = 1'b0;
    logic          e_we  = 1'b0;
    logic [AW-1:0] e_addr = a;
    logic [DW-1:0] e_wd  = wd;
    logic [DW-1:0] word;
    logic [AW-1:0] al = {a[AW-1:2], 2'b00};
    int            ix = a[5:2];
    check_rsp();
    up_valid = v; up_we = we; up_size = sz; up_addr = a; up_wdata = wd;
    #1;
    exp_rv = v; exp_re = 1'b0; exp_rd = '0; exp_tag = tag;
    if (v) begin
      if (sz == 2'd2) begin
        e_req = 1'b1; e_we = we;
        if (we) ref_mem[ix] = wd; else exp_rd = ref_mem[ix];
      end else if (sz == 2'd1) begin
        if (we && !a[1]) ref_stage = wd[15:0];
        else if (we) begin
          e_req = 1'b1; e_we = 1'b1; e_addr = al; e_wd = {wd[15:0], ref_stage};
          ref_mem[ix] = e_wd;
        end else if (!a[1]) begin
          e_req = 1'b1; e_addr = al; word = ref_mem[ix];
          exp_rd = {16'd0, word[15:0]}; ref_latch = word[31:16];
        end else exp_rd = {16'd0, ref_latch};
      end else exp_re = 1'b1;
    end
    chk(tag, "dn_req", {63'd0, dn_req}, {63'd0, e_req});
    if (e_req) begin
      chk(tag, "dn_addr", {52'd0, dn_addr}, {52'd0, e_addr});
      chk(tag, "dn_we", {63'd0, dn_we}, {63'd0, e_we});
      if (e_we) chk(tag, "dn_wdata", {32'd0, dn_wdata}, {32'd0, e_wd});
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      dev_mem[i] = (i * 32'h01010101) ^ 32'hA5A50000;
      ref_mem[i] = (i * 32'h01010101) ^ 32'hA5A50000;
    end
    ref_stage = '0; ref_latch = '0;
    exp_rv = 1'b0; exp_re = 1'b0; exp_rd = '0; exp_tag = "R1";
    rst = 1'b1; up_valid = 0; up_we = 0; up_size = 0; up_addr = '0; up_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values, latch and staging start at zero
    step(1, 0, 2'd1, 12'h006, '0, "R1");
    step(1, 1, 2'd1, 12'h00E, 32'h0000_7777, "R1");
    step(1, 0, 2'd2, 12'h00C, '0, "R1");
    // R2: word pass-through
    step(1, 1, 2'd2, 12'h008, 32'hDEAD_BEEF, "R2");
    step(1, 0, 2'd2, 12'h008, '0, "R2");
    // R3/R4/R9: staged write survives idle, word and refused traffic
    step(1, 1, 2'd1, 12'h010, 32'hFFFF_1234, "R3");
    step(0, 0, 2'd0, 12'h000, '0, "R8");
    step(1, 1, 2'd2, 12'h020, 32'h1111_2222, "R9");
    step(1, 1, 2'd0, 12'h011, 32'h0000_00EE, "R7");
    step(1, 1, 2'd1, 12'h012, 32'h0000_ABCD, "R4");
    step(1, 0, 2'd2, 12'h010, '0, "R4");
    // R5/R6/R9: fetch latches upper half, word read in between leaves latch
    step(1, 0, 2'd1, 12'h010, '0, "R5");
    step(1, 0, 2'd2, 12'h024, '0, "R9");
    step(1, 0, 2'd1, 12'h012, '0, "R6");
    // R7: byte and reserved sizes refused, latch untouched
    step(1, 0, 2'd0, 12'h013, '0, "R7");
    step(1, 0, 2'd3, 12'h014, '0, "R7");
    step(1, 0, 2'd1, 12'h016, '0, "R6");
    // random mix over sixteen words
    for (int n = 0; n < 4000; n++) begin
      logic          v  = ($urandom % 8) != 0;
      logic          we = $urandom % 2;
      logic [1:0]    sz = ($urandom % 10 == 0) ? 2'($urandom % 4) : 2'(1 + ($urandom % 2));
      logic [AW-1:0] a  = AW'($urandom);
      logic [DW-1:0] wd = $urandom;
      string tg;
      if (!v) tg = "R8";
      else if (sz == 2'd2) tg = "R2";
      else if (sz != 2'd1) tg = "R7";
      else if (we) tg = a[1] ? "R4" : "R3";
      else tg = a[1] ? "R6" : "R5";
      step(v, we, sz, a, wd, tg);
    end
    step(0, 0, 2'd0, '0, '0, "R8");
    check_rsp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule